// File: doc/BRIEF.md
# Home Directory Controller for MSI Coherence

This block is the home node for a slice of line addresses in a shared-memory system that uses point-to-point messages instead of a broadcast bus. For every line it owns, it keeps a directory entry: whether the line is uncached, held clean by one or more caches, or held dirty by one cache. The entry also records which cache holds the dirty copy, and a bit vector of the caches that hold clean copies. The memory data for the slice sits beside the directory.

Processors send read and write requests into a small request queue. The controller decides from the directory entry what has to happen. It may answer at once from memory, forward the read to the dirty holder, or invalidate exactly the caches that hold copies. Only caches named in the entry ever receive a message. While acknowledgements for a line are outstanding, that line is marked busy. A request to a busy line waits at the head of the queue, and every request behind it waits too, until the last acknowledgement arrives. The controller then answers the requester or closes the transaction.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every line is uncached, `out_valid` is low, and `req_ready` and `ack_ready` are high.
- R2: A read (type 0) to an uncached or clean-shared line is answered with one shared-data reply (type 2) to the requester, carrying the line's memory data. Memory data starts at 0xA500 + 0x11 times the line index.
- R3: A read to a line held dirty by another cache sends one forward (type 4) to the dirty holder, with `out_req` set to the requester. The holder's writeback acknowledgement (type 7) stores `ack_data` in memory. Both caches then become clean sharers, and no reply follows.
- R4: A write (type 1) sends one invalidation (type 5) to each current holder other than the requester, in ascending processor id. After one acknowledgement (type 6 or 7) per invalidation, an exclusive grant (type 3) with the line's memory data goes to the requester, and the line becomes dirty with the requester as holder.
- R5: A processor that holds no copy of a line receives no message for a request to that line.
- R6: While a line has outstanding acknowledgements, a request to it produces no output. Requests queued behind it also wait, and all of them are served in arrival order once the last acknowledgement arrives.
- R7: A read or write from the cache that already holds the line dirty is answered at once with an exclusive grant, and nothing is forwarded or invalidated.
- R8: An acknowledgement for a line with no open transaction is accepted and has no effect on memory data, directory state or output.
- R9: While `out_valid` is high and `out_ready` is low, the output message stays unchanged.
- R10: `req_ready` goes low when the request queue holds `FIFO_DEPTH` entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Request queue can accept |
| req_type | input | 3 | Request type (0 read, 1 write) |
| req_src | input | PID_W | Requesting processor id |
| req_addr | input | LA_W | Line index within this home |
| ack_valid | input | 1 | Acknowledgement present |
| ack_ready | output | 1 | Acknowledgement accepted |
| ack_type | input | 3 | 6 plain ack, 7 ack with writeback data |
| ack_addr | input | LA_W | Line being acknowledged |
| ack_data | input | DATA_W | Writeback data |
| out_valid | output | 1 | Outgoing message present |
| out_ready | input | 1 | Network accepts the outgoing message |
| out_type | output | 3 | 2 shared data, 3 exclusive grant, 4 forward, 5 invalidate |
| out_dst | output | PID_W | Destination processor |
| out_req | output | PID_W | Original requester of the transaction |
| out_addr | output | LA_W | Line index |
| out_data | output | DATA_W | Line data from memory |

## Verification
The hardest state to reach is a full request queue whose head targets a busy line while the entries behind it target idle lines. Only that state shows whether the controller blocks and then releases strictly in order. The bench gets there by issuing a write to a dirty line, taking the invalidation and holding back the acknowledgement. It then fills the queue with one request to the same line and three to other lines, and checks the stall, the full flag and the exact order of replies after the withheld acknowledgement is delivered. The same method of withholding an acknowledgement is used to show that a second request to a line stays silent mid-transaction.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [2:0] {
    MSG_RD      = 3'd0,
    MSG_WR      = 3'd1,
    MSG_DATA_S  = 3'd2,
    MSG_GRANT_M = 3'd3,
    MSG_FWD     = 3'd4,
    MSG_INV     = 3'd5,
    MSG_ACK_INV = 3'd6,
    MSG_ACK_WB  = 3'd7
  } msg_t;

  typedef enum logic [1:0] {
    LN_UNC = 2'd0,
    LN_SHD = 2'd1,
    LN_MOD = 2'd2
  } lstate_t;

  typedef enum logic [1:0] {
    CT_IDLE  = 2'd0,
    CT_FAN   = 2'd1,
    CT_REPLY = 2'd2
  } ctl_t;

  // index of the lowest set bit (0 when none)
  function automatic logic [31:0] first_set(input logic [31:0] v);
    logic [31:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  function automatic logic [31:0] ones_in(input logic [31:0] v);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) r = r + {31'd0, v[i]};
    return r;
  endfunction

  // initial memory content of a line
  function automatic logic [31:0] line_seed(input logic [31:0] idx);
    return 32'hA500 + idx * 32'h11;
  endfunction

endpackage

// File: rtl/dir_req_fifo.sv
module dir_req_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign dout  = slot_q[rp_q];

  always_ff @(posedge clk) begin
    if (push) slot_q[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= bump(wp_q);
      if (pop)  rp_q <= bump(rp_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_pop_nonempty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/dir_line_table.sv
module dir_line_table
  import dir_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int NLINES = 8,
  parameter int DATA_W = 16,
  localparam int PID_W = $clog2(NPROC),
  localparam int LA_W  = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [LA_W-1:0]   upd_addr,
  input  lstate_t           upd_st,
  input  logic [PID_W-1:0]  upd_owner,
  input  logic [NPROC-1:0]  upd_shr,
  input  logic              wb_en,
  input  logic [LA_W-1:0]   wb_addr,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [LA_W-1:0]   rd_addr,
  output lstate_t           rd_st,
  output logic [PID_W-1:0]  rd_owner,
  output logic [NPROC-1:0]  rd_shr,
  input  logic [LA_W-1:0]   dat_addr,
  output logic [DATA_W-1:0] dat_out
);
  lstate_t           st_q    [NLINES];
  logic [PID_W-1:0]  owner_q [NLINES];
  logic [NPROC-1:0]  shr_q   [NLINES];
  logic [DATA_W-1:0] mem_q   [NLINES];

  assign rd_st    = st_q[rd_addr];
  assign rd_owner = owner_q[rd_addr];
  assign rd_shr   = shr_q[rd_addr];
  assign dat_out  = mem_q[dat_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) begin
        st_q[i]    <= LN_UNC;
        owner_q[i] <= '0;
        shr_q[i]   <= '0;
        mem_q[i]   <= DATA_W'(line_seed(32'(i)));
      end
    end else begin
      if (upd_en) begin
        st_q[upd_addr]    <= upd_st;
        owner_q[upd_addr] <= upd_owner;
        shr_q[upd_addr]   <= upd_shr;
      end
      if (wb_en) mem_q[wb_addr] <= wb_data;
    end
  end

  p_mod_no_sharers_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && upd_st == LN_MOD |-> upd_shr == '0);
  p_shared_has_holder_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && upd_st == LN_SHD |-> upd_shr != '0);

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NPROC      = 4,
  parameter int NLINES     = 8,
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4,
  localparam int PID_W = $clog2(NPROC),
  localparam int LA_W  = $clog2(NLINES),
  localparam int CNT_W = $clog2(NPROC + 1),
  localparam int RQ_W  = 3 + PID_W + LA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_type,
  input  logic [PID_W-1:0]  req_src,
  input  logic [LA_W-1:0]   req_addr,
  input  logic              ack_valid,
  output logic              ack_ready,
  input  logic [2:0]        ack_type,
  input  logic [LA_W-1:0]   ack_addr,
  input  logic [DATA_W-1:0] ack_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_type,
  output logic [PID_W-1:0]  out_dst,
  output logic [PID_W-1:0]  out_req,
  output logic [LA_W-1:0]   out_addr,
  output logic [DATA_W-1:0] out_data
);
  // ---------------- request queue ----------------
  logic [RQ_W-1:0] head;
  logic            q_full, q_empty, pop;
  logic [2:0]      h_type;
  logic [PID_W-1:0] h_src;
  logic [LA_W-1:0] h_addr;

  assign req_ready = !q_full;

  dir_req_fifo #(.W(RQ_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(req_valid && !q_full), .din({req_type, req_src, req_addr}),
    .pop(pop), .dout(head), .full(q_full), .empty(q_empty)
  );
  assign {h_type, h_src, h_addr} = head;

  // ---------------- per-line transaction state ----------------
  logic [NLINES-1:0] busy_q;
  logic [CNT_W-1:0]  pend_q   [NLINES];
  logic [PID_W-1:0]  preq_q   [NLINES];
  logic [PID_W-1:0]  powner_q [NLINES];
  logic [NLINES-1:0] pwr_q;

  ctl_t             st_q;
  logic [NPROC-1:0] fan_mask_q;
  msg_t             fan_type_q, rep_type_q;
  logic [PID_W-1:0] fan_req_q, rep_dst_q;
  logic [LA_W-1:0]  fan_addr_q, rep_addr_q;

  // ---------------- directory table ----------------
  logic              upd_en, wb_en;
  logic [LA_W-1:0]   upd_addr;
  lstate_t           upd_st, rd_st;
  logic [PID_W-1:0]  upd_owner, rd_owner;
  logic [NPROC-1:0]  upd_shr, rd_shr;
  logic [DATA_W-1:0] line_data;

  dir_line_table #(.NPROC(NPROC), .NLINES(NLINES), .DATA_W(DATA_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .upd_en(upd_en), .upd_addr(upd_addr), .upd_st(upd_st),
    .upd_owner(upd_owner), .upd_shr(upd_shr),
    .wb_en(wb_en), .wb_addr(ack_addr), .wb_data(ack_data),
    .rd_addr(h_addr), .rd_st(rd_st), .rd_owner(rd_owner), .rd_shr(rd_shr),
    .dat_addr(out_addr), .dat_out(line_data)
  );

  // ---------------- named events ----------------
  logic             ack_fire, ack_hit, ack_last, disp;
  logic [NPROC-1:0] req_bit, own_bit, holders, targets, fan_next;
  logic             open_txn, do_reply;
  logic [NPROC-1:0] open_mask;
  msg_t             open_type, reply_type;

  assign ack_ready = (st_q == CT_IDLE);
  assign ack_fire  = ack_valid && ack_ready;
  assign ack_hit   = ack_fire && busy_q[ack_addr];
  assign ack_last  = ack_hit && pend_q[ack_addr] == CNT_W'(1);
  assign disp      = (st_q == CT_IDLE) && !ack_valid && !q_empty && !busy_q[h_addr];
  assign pop       = disp;
  assign wb_en     = ack_hit && ack_type == MSG_ACK_WB;

  assign req_bit  = NPROC'(1) << h_src;
  assign own_bit  = NPROC'(1) << rd_owner;
  assign holders  = (rd_st == LN_MOD) ? own_bit : (rd_st == LN_SHD) ? rd_shr : '0;
  assign targets  = holders & ~req_bit;
  assign fan_next = fan_mask_q & (fan_mask_q - 1'b1);

  always_comb begin
    upd_en     = 1'b0;
    upd_addr   = h_addr;
    upd_st     = LN_UNC;
    upd_owner  = '0;
    upd_shr    = '0;
    open_txn   = 1'b0;
    open_mask  = '0;
    open_type  = MSG_INV;
    do_reply   = 1'b0;
    reply_type = MSG_GRANT_M;
    if (ack_last) begin
      upd_en   = 1'b1;
      upd_addr = ack_addr;
      if (pwr_q[ack_addr]) begin
        upd_st    = LN_MOD;
        upd_owner = preq_q[ack_addr];
      end else begin
        upd_st  = LN_SHD;
        upd_shr = (NPROC'(1) << powner_q[ack_addr]) | (NPROC'(1) << preq_q[ack_addr]);
      end
    end else if (disp) begin
      if (h_type == MSG_WR) begin
        if (targets == '0) begin
          upd_en    = 1'b1;
          upd_st    = LN_MOD;
          upd_owner = h_src;
          do_reply  = 1'b1;
        end else begin
          open_txn  = 1'b1;
          open_mask = targets;
        end
      end else if (rd_st == LN_MOD) begin
        if (rd_owner == h_src) begin
          do_reply = 1'b1;
        end else begin
          open_txn  = 1'b1;
          open_mask = own_bit;
          open_type = MSG_FWD;
        end
      end else begin
        upd_en     = 1'b1;
        upd_st     = LN_SHD;
        upd_shr    = rd_shr | req_bit;
        do_reply   = 1'b1;
        reply_type = MSG_DATA_S;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= CT_IDLE;
      busy_q     <= '0;
      pwr_q      <= '0;
      fan_mask_q <= '0;
      fan_type_q <= MSG_INV;
      fan_req_q  <= '0;
      fan_addr_q <= '0;
      rep_type_q <= MSG_GRANT_M;
      rep_dst_q  <= '0;
      rep_addr_q <= '0;
      for (int i = 0; i < NLINES; i++) begin
        pend_q[i]   <= '0;
        preq_q[i]   <= '0;
        powner_q[i] <= '0;
      end
    end else begin
      case (st_q)
        CT_IDLE: begin
          if (ack_hit) begin
            pend_q[ack_addr] <= pend_q[ack_addr] - 1'b1;
            if (ack_last) begin
              busy_q[ack_addr] <= 1'b0;
              if (pwr_q[ack_addr]) begin
                rep_type_q <= MSG_GRANT_M;
                rep_dst_q  <= preq_q[ack_addr];
                rep_addr_q <= ack_addr;
                st_q       <= CT_REPLY;
              end
            end
          end else if (open_txn) begin
            busy_q[h_addr]   <= 1'b1;
            pend_q[h_addr]   <= CNT_W'(ones_in(32'(open_mask)));
            preq_q[h_addr]   <= h_src;
            powner_q[h_addr] <= rd_owner;
            pwr_q[h_addr]    <= (h_type == MSG_WR);
            fan_mask_q       <= open_mask;
            fan_type_q       <= open_type;
            fan_req_q        <= h_src;
            fan_addr_q       <= h_addr;
            st_q             <= CT_FAN;
          end else if (do_reply) begin
            rep_type_q <= reply_type;
            rep_dst_q  <= h_src;
            rep_addr_q <= h_addr;
            st_q       <= CT_REPLY;
          end
        end
        CT_FAN: begin
          if (out_ready) begin
            fan_mask_q <= fan_next;
            if (fan_next == '0) st_q <= CT_IDLE;
          end
        end
        default: begin
          if (out_ready) st_q <= CT_IDLE;
        end
      endcase
    end
  end

  // ---------------- outgoing message ----------------
  assign out_valid = (st_q != CT_IDLE);
  assign out_type  = (st_q == CT_FAN) ? fan_type_q : rep_type_q;
  assign out_dst   = (st_q == CT_FAN) ? PID_W'(first_set(32'(fan_mask_q))) : rep_dst_q;
  assign out_req   = (st_q == CT_FAN) ? fan_req_q : rep_dst_q;
  assign out_addr  = (st_q == CT_FAN) ? fan_addr_q : rep_addr_q;
  assign out_data  = line_data;

  // ---------------- assertions ----------------
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_type) && $stable(out_dst)
      && $stable(out_req) && $stable(out_addr) && $stable(out_data));
  p_reply_unblocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_type == MSG_DATA_S || out_type == MSG_GRANT_M) |-> !busy_q[out_addr]);
  p_no_self_inv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_type == MSG_INV |-> out_dst != preq_q[out_addr]);
  p_ack_counted_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |-> pend_q[ack_addr] != '0);
  p_head_waits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !$past(busy_q[h_addr]));

endmodule

// File: tb/dir_home_ctrl_tb.sv
module dir_home_ctrl_tb;
  localparam int NPROC = 4, NLINES = 8, DATA_W = 16, FIFO_DEPTH = 4;
  localparam int PID_W = 2, LA_W = 3;
  localparam logic [2:0] T_RD = 3'd0, T_WR = 3'd1, T_DS = 3'd2, T_GM = 3'd3,
                         T_FW = 3'd4, T_IV = 3'd5, T_AI = 3'd6, T_AW = 3'd7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, ack_valid = 1'b0, out_ready = 1'b0;
  logic req_ready, ack_ready, out_valid;
  logic [2:0] req_type = '0, ack_type = '0, out_type;
  logic [PID_W-1:0] req_src = '0, out_dst, out_req;
  logic [LA_W-1:0] req_addr = '0, ack_addr = '0, out_addr;
  logic [DATA_W-1:0] ack_data = '0, out_data;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dir_home_ctrl #(.NPROC(NPROC), .NLINES(NLINES), .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_src(req_src), .req_addr(req_addr),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_type(ack_type),
    .ack_addr(ack_addr), .ack_data(ack_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type),
    .out_dst(out_dst), .out_req(out_req), .out_addr(out_addr), .out_data(out_data)
  );

  function automatic logic [15:0] seed(input int idx);
    return 16'hA500 + 16'(idx) * 16'h0011;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_req(input logic [2:0] t, input int src, input int addr);
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_src = PID_W'(src); req_addr = LA_W'(addr);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1 req_valid = 1'b0;
  endtask

  task automatic send_ack(input logic [2:0] t, input int addr, input logic [15:0] d);
    @(negedge clk);
    ack_valid = 1'b1; ack_type = t; ack_addr = LA_W'(addr); ack_data = d;
    while (!ack_ready) @(negedge clk);
    @(posedge clk); #1 ack_valid = 1'b0;
  endtask

  task automatic expect_msg(input string tag, input logic [2:0] et, input int edst,
                            input int ereq, input int eaddr, input bit dchk,
                            input logic [15:0] edata);
    int n = 0;
    @(negedge clk);
    out_ready = 1'b1;
    while (!out_valid && n < 100) begin @(negedge clk); n++; end
    if (!out_valid) begin
      checks++; errors++;
      $display("FAIL %s: actual no message expected type %0d", tag, et);
      out_ready = 1'b0;
    end else begin
      check({tag, " type"}, 32'(out_type), 32'(et));
      check({tag, " dst"}, 32'(out_dst), 32'(edst));
      check({tag, " req"}, 32'(out_req), 32'(ereq));
      check({tag, " addr"}, 32'(out_addr), 32'(eaddr));
      if (dchk) check({tag, " data"}, 32'(out_data), 32'(edata));
      @(posedge clk); #1 out_ready = 1'b0;
    end
  endtask

  task automatic expect_quiet(input string tag, input int cycles);
    bit seen = 0;
    @(negedge clk);
    out_ready = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      if (out_valid) seen = 1;
      @(negedge clk);
    end
    out_ready = 1'b0;
    check({tag, " quiet"}, 32'(seen), 32'd0);
  endtask

  // R1
  task automatic t_reset();
    @(negedge clk);
    check("R1 out_valid", 32'(out_valid), 32'd0);
    check("R1 req_ready", 32'(req_ready), 32'd1);
    check("R1 ack_ready", 32'(ack_ready), 32'd1);
  endtask

  // R2: two readers of an uncached line
  task automatic t_read_clean();
    send_req(T_RD, 1, 0);
    expect_msg("R2 first reader", T_DS, 1, 1, 0, 1, seed(0));
    send_req(T_RD, 2, 0);
    expect_msg("R2 second reader", T_DS, 2, 2, 0, 1, seed(0));
  endtask

  // R4 R5 R6 R9: write over sharers {1,2}, then a read while acks pend
  task automatic t_write_over_sharers();
    logic [2:0] t0; logic [PID_W-1:0] d0; logic [15:0] x0; bit moved = 0;
    send_req(T_WR, 3, 0);
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    t0 = out_type; d0 = out_dst; x0 = out_data;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!out_valid || out_type !== t0 || out_dst !== d0 || out_data !== x0) moved = 1;
    end
    check("R9 held while stalled", 32'(moved), 32'd0);
    expect_msg("R4 inv lowest sharer", T_IV, 1, 3, 0, 0, '0);
    expect_msg("R4 inv next sharer", T_IV, 2, 3, 0, 0, '0);
    expect_quiet("R5 no extra inv", 4);
    send_req(T_RD, 0, 0);
    expect_quiet("R6 blocked read", 6);
    send_ack(T_AI, 0, '0);
    expect_quiet("R4 partial acks", 3);
    send_ack(T_AI, 0, '0);
    expect_msg("R4 grant after acks", T_GM, 3, 3, 0, 1, seed(0));
    expect_msg("R3 forward to holder", T_FW, 3, 0, 0, 0, '0);
    send_ack(T_AW, 0, 16'h1234);
    expect_quiet("R3 no reply after wb", 4);
  endtask

  // R3: line 0 is now clean at {0,3}, memory 0x1234
  task automatic t_after_forward();
    send_req(T_WR, 1, 0);
    expect_msg("R3 inv sharer 0", T_IV, 0, 1, 0, 0, '0);
    expect_msg("R3 inv sharer 3", T_IV, 3, 1, 0, 0, '0);
    expect_quiet("R5 only sharers", 3);
    send_ack(T_AI, 0, '0);
    send_ack(T_AI, 0, '0);
    expect_msg("R3 grant carries wb data", T_GM, 1, 1, 0, 1, 16'h1234);
  endtask

  // R7: holder re-requests
  task automatic t_owner_again();
    send_req(T_WR, 1, 2);
    expect_msg("R4 grant uncached", T_GM, 1, 1, 2, 1, seed(2));
    send_req(T_RD, 1, 2);
    expect_msg("R7 holder read", T_GM, 1, 1, 2, 1, seed(2));
    send_req(T_WR, 1, 2);
    expect_msg("R7 holder write", T_GM, 1, 1, 2, 1, seed(2));
    expect_quiet("R7 nothing forwarded", 4);
  endtask

  // R8: stray ack on idle line 5
  task automatic t_stray_ack();
    send_ack(T_AW, 5, 16'hDEAD);
    expect_quiet("R8 stray ack", 4);
    send_req(T_RD, 2, 5);
    expect_msg("R8 memory untouched", T_DS, 2, 2, 5, 1, seed(5));
  endtask

  // R6 R10: blocked head with other lines queued behind
  task automatic t_blocked_queue();
    send_req(T_WR, 0, 2);
    expect_msg("R4 inv dirty holder", T_IV, 1, 0, 2, 0, '0);
    send_req(T_RD, 2, 2);
    send_req(T_RD, 3, 4);
    send_req(T_RD, 0, 6);
    send_req(T_RD, 2, 7);
    @(negedge clk);
    check("R10 queue full", 32'(req_ready), 32'd0);
    expect_quiet("R6 head of line", 5);
    send_ack(T_AW, 2, 16'hBEEF);
    expect_msg("R6 grant first", T_GM, 0, 0, 2, 1, 16'hBEEF);
    expect_msg("R6 queued read forwards", T_FW, 0, 2, 2, 0, '0);
    expect_msg("R6 line 4 next", T_DS, 3, 3, 4, 1, seed(4));
    expect_msg("R6 line 6 next", T_DS, 0, 0, 6, 1, seed(6));
    expect_msg("R6 line 7 last", T_DS, 2, 2, 7, 1, seed(7));
    @(negedge clk);
    check("R10 queue drained", 32'(req_ready), 32'd1);
    send_ack(T_AW, 2, 16'h5A5A);
    expect_quiet("R3 forward closed", 3);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_read_clean();
    t_write_over_sharers();
    t_after_forward();
    t_owner_again();
    t_stray_ack();
    t_blocked_queue();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule